// File: doc/BRIEF.md
# High-Speed SCL Clock Generator with Stretch Detection

This block produces the serial clock for an I2C master running in high-speed mode. The high and low halves of each SCL period are set by two separate counts, in system clock cycles, so the asymmetric duty cycle of high-speed mode can be programmed directly. A typical setting gives about one third of the period high and two thirds low, for a 3.4 Mbit/s rate. An odd high count is rounded up by one cycle to absorb rounding error in the count calculation.

The output is open-drain. The block either pulls SCL low or lets it go, and never drives it high. A phase counter does not start when the drive changes. It starts only once the synchronised, filtered SCL input shows the new level. A slave that holds SCL low therefore lengthens the period, and the latency of the input path adds to every phase. Single-cycle strobes mark each rising and falling edge seen on the synchronised input. START/STOP, data shifting and arbitration belong to neighbouring blocks.

Top module: `scl_hs_clkgen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclDriveLow`, `sclRise` and `sclFall` are all 0.
- R2: After `enable` rises, the block starts with a released (high) phase. While the SCL line is already high, the first drive-low comes `effHigh + 1` cycles after the clock edge that samples `enable`.
- R3: In steady running with no stretching, SCL is released for exactly `effHigh + 3` cycles per period. The high count starts only when the two-flop synchronised input reads 1, and the 3 extra cycles are the synchroniser stages plus the detection cycle.
- R4: In steady running, SCL is driven low for exactly `effLow + 3` cycles per period. `effLow` equals `lowCount`, with 0 taken as 1.
- R5: `effHigh` is `highCount + 1` when bit 0 of `highCount` is 1 and `highCount` otherwise. For example, 5 gives 6 and 4 stays 4.
- R6: A count of 0 is treated as 1 for both phases, so no phase is shorter than 4 cycles.
- R7: If another device holds SCL low for S extra cycles after the block releases it, the released interval grows to `S + effHigh + 3`.
- R8: When `enable` is 0 at a clock edge, SCL is released from that edge on and stays released. Phase and counter state restart, so re-enabling begins again with the R2 behaviour.
- R9: `sclRise` and `sclFall` each pulse for exactly one cycle per edge of the synchronised SCL level while enabled. There is one of each per SCL period, and neither pulses while `enable` is 0, even if the line toggles.
- R10: A delay of D cycles on the SCL input path (the input filter) lengthens both the released and the driven-low intervals by D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the clock generator |
| highCount | input | CNT_W | Programmed high-phase count, before rounding |
| lowCount | input | CNT_W | Programmed low-phase count |
| sclIn | input | 1 | Filtered SCL level read back from the bus |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sclRise | output | 1 | One-cycle pulse on an observed rising edge |
| sclFall | output | 1 | One-cycle pulse on an observed falling edge |

## Verification
A wrong phase or counter value shows up as a released or driven-low interval of the wrong length, visible at `sclDriveLow` within one SCL period. A counter loaded with the unrounded high count is off by exactly one cycle on odd counts. A generator that starts counting at the drive change, rather than at detection, is three cycles short per phase and ignores stretching. A bad edge detector shows as missing, doubled or wide strobe pulses within the same period, or as strobes while disabled.

// File: rtl/scl_hs_clkgen_pkg.sv
package scl_hs_clkgen_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_HIGH_WAIT = 3'd1,
    PH_HIGH_RUN  = 3'd2,
    PH_LOW_WAIT  = 3'd3,
    PH_LOW_RUN   = 3'd4
  } phase_e;

  typedef struct packed {
    logic clear;
    logic loadHigh;
    logic loadLow;
    logic countDown;
  } ctrlStrobes_t;

endpackage

// File: rtl/scl_hs_clkgen_datapath.sv
module scl_hs_clkgen_datapath
  import scl_hs_clkgen_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] highCount,
  input  logic [CNT_W-1:0] lowCount,
  input  logic             sclIn,
  input  ctrlStrobes_t     strobes,
  output logic             syncScl,
  output logic             cntZero,
  output logic             sclRise,
  output logic             sclFall
);

  localparam int RUN_W = CNT_W + 1;

  // Input synchroniser; resets to the idle-high bus level
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevScl;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= sclIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], sclIn};
      end
    end
  endgenerate

  assign syncScl = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevScl <= 1'b1;
    else       prevScl <= syncScl;
  end

  assign sclRise = enable &  syncScl & ~prevScl;
  assign sclFall = enable & ~syncScl &  prevScl;

  // Effective phase lengths
  function automatic logic [RUN_W-1:0] roundHigh(input logic [CNT_W-1:0] c);
    if (c == '0) return RUN_W'(1);
    return {1'b0, c} + RUN_W'(c[0]);
  endfunction

  function automatic logic [RUN_W-1:0] floorLow(input logic [CNT_W-1:0] c);
    if (c == '0) return RUN_W'(1);
    return {1'b0, c};
  endfunction

  logic [RUN_W-1:0] effHigh;
  logic [RUN_W-1:0] effLow;
  logic [RUN_W-1:0] phaseCnt;

  assign effHigh = roundHigh(highCount);
  assign effLow  = floorLow(lowCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  phaseCnt <= '0;
    else if (strobes.clear)     phaseCnt <= '0;
    else if (strobes.loadHigh)  phaseCnt <= effHigh - RUN_W'(1);
    else if (strobes.loadLow)   phaseCnt <= effLow - RUN_W'(1);
    else if (strobes.countDown) phaseCnt <= phaseCnt - RUN_W'(1);
  end

  assign cntZero = (phaseCnt == '0);

  // The control must never decrement an exhausted counter
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.countDown |-> !cntZero);

  // A strobe lasts exactly one cycle
  assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    sclRise |=> !sclRise);

  assert_fall_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |=> !sclFall);

endmodule

// File: rtl/scl_hs_clkgen_ctrl.sv
module scl_hs_clkgen_ctrl
  import scl_hs_clkgen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         syncScl,
  input  logic         cntZero,
  output ctrlStrobes_t strobes,
  output logic         sclDriveLow
);

  phase_e phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    strobes   = '0;
    if (!enable) begin
      phaseNext     = PH_IDLE;
      strobes.clear = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: phaseNext = PH_HIGH_WAIT;
        PH_HIGH_WAIT: if (syncScl) begin
          phaseNext        = PH_HIGH_RUN;
          strobes.loadHigh = 1'b1;
        end
        PH_HIGH_RUN: if (cntZero) phaseNext = PH_LOW_WAIT;
                     else         strobes.countDown = 1'b1;
        PH_LOW_WAIT: if (!syncScl) begin
          phaseNext       = PH_LOW_RUN;
          strobes.loadLow = 1'b1;
        end
        PH_LOW_RUN: if (cntZero) phaseNext = PH_HIGH_WAIT;
                    else         strobes.countDown = 1'b1;
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      sclDriveLow <= 1'b0;
    end else begin
      phase       <= phaseNext;
      sclDriveLow <= (phaseNext == PH_LOW_WAIT) || (phaseNext == PH_LOW_RUN);
    end
  end

  // The high count only starts once the line is seen high
  assert_high_after_detect_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH_RUN && $past(phase) == PH_HIGH_WAIT) |-> $past(syncScl));

  // The low count only starts once the line is seen low
  assert_low_after_detect_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LOW_RUN && $past(phase) == PH_LOW_WAIT) |-> !$past(syncScl));

  // Pulling low only follows an exhausted high count
  assert_low_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> $past(cntZero) && $past(phase) == PH_HIGH_RUN);

  // Disable releases the line at the next edge
  assert_release_on_disable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sclDriveLow);

endmodule

// File: rtl/scl_hs_clkgen.sv
module scl_hs_clkgen
  import scl_hs_clkgen_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] highCount,
  input  logic [CNT_W-1:0] lowCount,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             sclRise,
  output logic             sclFall
);

  ctrlStrobes_t strobes;
  logic         syncScl;
  logic         cntZero;

  scl_hs_clkgen_datapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .highCount(highCount),
    .lowCount (lowCount),
    .sclIn    (sclIn),
    .strobes  (strobes),
    .syncScl  (syncScl),
    .cntZero  (cntZero),
    .sclRise  (sclRise),
    .sclFall  (sclFall)
  );

  scl_hs_clkgen_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .syncScl    (syncScl),
    .cntZero    (cntZero),
    .strobes    (strobes),
    .sclDriveLow(sclDriveLow)
  );

endmodule

// File: tb/scl_hs_clkgen_tb.sv
module scl_hs_clkgen_tb;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [CNT_W-1:0] highCount = 8'd5;
  logic [CNT_W-1:0] lowCount = 8'd10;
  logic             sclIn;
  logic             sclDriveLow, sclRise, sclFall;

  logic       holdLow = 1'b0;
  int         lineDelay = 0;
  logic       busLine;
  logic [7:0] lineHist = '1;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  assign busLine = !sclDriveLow && !holdLow;
  always @(posedge clk) lineHist <= {lineHist[6:0], busLine};
  always_comb sclIn = (lineDelay == 0) ? busLine : lineHist[lineDelay-1];

  scl_hs_clkgen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .highCount(highCount),
    .lowCount(lowCount), .sclIn(sclIn), .sclDriveLow(sclDriveLow),
    .sclRise(sclRise), .sclFall(sclFall)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int effHigh(input int c);
    if (c == 0) return 1;
    return c + (c % 2);
  endfunction

  function automatic int effLow(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  // Counts negedge samples at a constant drive level; returns at the first sample of the next phase
  task automatic phaseLen(output int len);
    logic lvl;
    lvl = sclDriveLow;
    len = 1;
    @(negedge clk);
    while (sclDriveLow == lvl) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic alignLowStart();
    @(negedge clk);
    while (sclDriveLow) @(negedge clk);
    while (!sclDriveLow) @(negedge clk);
  endtask

  task automatic restart(input int hc, input int lc);
    @(negedge clk);
    enable = 1'b0;
    highCount = CNT_W'(hc);
    lowCount = CNT_W'(lc);
    repeat (4) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic testReset();
    // R1
    check("R1 drive in reset", int'(sclDriveLow), 0);
    check("R1 rise in reset", int'(sclRise), 0);
    check("R1 fall in reset", int'(sclFall), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 drive after reset", int'(sclDriveLow), 0);
    check("R1 strobes after reset", int'(sclRise) + int'(sclFall), 0);
  endtask

  task automatic testStartup(input int hc, input int lc);
    int n;
    @(negedge clk);
    enable = 1'b0;
    highCount = CNT_W'(hc);
    lowCount = CNT_W'(lc);
    repeat (4) @(negedge clk);
    enable = 1'b1;
    n = 0;
    @(negedge clk);
    while (!sclDriveLow && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R2 first released interval", n, effHigh(hc) + 1);
  endtask

  task automatic testSteady(input int hc, input int lc, input string tagH, input string tagL);
    int lenL, lenH;
    restart(hc, lc);
    alignLowStart();
    phaseLen(lenL);
    phaseLen(lenH);
    check({tagL, " low interval"}, lenL, effLow(lc) + 3 + lineDelay);
    check({tagH, " high interval"}, lenH, effHigh(hc) + 3 + lineDelay);
    phaseLen(lenL);
    check({tagL, " low interval repeat"}, lenL, effLow(lc) + 3 + lineDelay);
  endtask

  task automatic testStretch(input int hc, input int lc, input int s);
    int len;
    restart(hc, lc);
    alignLowStart();
    holdLow = 1'b1;
    @(negedge clk);
    while (sclDriveLow) @(negedge clk);
    len = 1;
    repeat (s) begin
      @(negedge clk);
      if (!sclDriveLow) len++;
    end
    holdLow = 1'b0;
    @(negedge clk);
    while (!sclDriveLow) begin
      len++;
      @(negedge clk);
    end
    check("R7 stretched released interval", len, s + effHigh(hc) + 3);
  endtask

  task automatic testDisable(input int hc, input int lc);
    int driven;
    restart(hc, lc);
    alignLowStart();
    enable = 1'b0;
    @(negedge clk);
    check("R8 released after disable", int'(sclDriveLow), 0);
    driven = 0;
    repeat (20) begin
      @(negedge clk);
      driven += int'(sclDriveLow);
    end
    check("R8 stays released while disabled", driven, 0);
    testStartup(hc, lc);
  endtask

  task automatic testStrobes(input int hc, input int lc);
    int rises, falls, wideR, wideF, lenA, lenB;
    logic pr, pf;
    restart(hc, lc);
    alignLowStart();
    rises = 0; falls = 0; wideR = 0; wideF = 0; pr = 0; pf = 0;
    lenA = 3 * (effHigh(hc) + effLow(lc) + 6);
    repeat (lenA) begin
      @(negedge clk);
      rises += int'(sclRise);
      falls += int'(sclFall);
      if (pr && sclRise) wideR++;
      if (pf && sclFall) wideF++;
      pr = sclRise; pf = sclFall;
    end
    check("R9 rise pulses over three periods", rises, 3);
    check("R9 fall pulses over three periods", falls, 3);
    check("R9 strobe width", wideR + wideF, 0);
    // Disabled: toggle the line and expect silence
    enable = 1'b0;
    lenB = 0;
    repeat (6) begin
      holdLow = ~holdLow;
      repeat (5) begin
        @(negedge clk);
        lenB += int'(sclRise) + int'(sclFall);
      end
    end
    holdLow = 1'b0;
    check("R9 no strobes while disabled", lenB, 0);
  endtask

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testStartup(5, 10);
    testSteady(4, 8, "R3", "R4");
    testSteady(5, 10, "R5", "R4");
    testSteady(7, 3, "R5", "R4");
    testSteady(0, 0, "R6", "R6");
    testSteady(1, 2, "R5", "R4");
    testStretch(5, 10, 7);
    testStretch(2, 4, 1);
    lineDelay = 2;
    testSteady(6, 12, "R10", "R10");
    lineDelay = 0;
    testDisable(3, 6);
    testStrobes(5, 10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule